// File: doc/BRIEF.md
# Watched-line alert monitor

This block keeps a small table of cache lines that software has asked to watch through a special alert-marking load. As long as a line stays in the table, its watch tag is live. The tag is lost when another agent takes exclusive ownership of the line, which invalidates it, or when the cache has to drop the line for lack of room. The block then reports the loss to the processor as an asynchronous alert. The alert carries a cause bit and the address of the line.

After one alert has been delivered, further alerts are masked until software signals that its handler has finished. While the mask is set, the first new loss is held as a single pending alert and any later losses are dropped. The pending alert is delivered on the cycle after the handler exits. A release input drops every tag at once without raising an alert. Data storage, the real cache and the coherence fabric are outside the block; the events arrive on plain strobe-and-address ports.

Top module: `line_watch_monitor`

## Requirements
- R1: A mark request for an address that no live entry holds stores that address in the lowest-numbered free entry and sets its tag. Marking an address that is already held changes nothing.
- R2: An exclusive snoop (`snp_valid`=1, `snp_excl`=1) that hits a tagged line clears the tag. While unmasked, this raises an alert in the cycle after the snoop is sampled, with `alert_cause`=0 (coherence) and `alert_addr` equal to the snoop address.
- R3: An eviction that hits a tagged line clears the tag. While unmasked, this raises an alert in the next cycle with `alert_cause`=1 (capacity) and the eviction address.
- R4: Once an alert has been delivered, no further alert appears until `handler_exit` is sampled high. `handler_exit` has no effect while the block is unmasked.
- R5: While masked, the first new event is held as pending, with its cause and address, and later events are dropped, although their tags are still cleared. `handler_exit` with an event pending delivers that event in the next cycle and keeps the mask set. `handler_exit` with nothing pending clears the mask.
- R6: An exclusive snoop or an eviction to an address that no live entry holds raises no alert and leaves every tag unchanged.
- R7: A shared snoop (`snp_valid`=1, `snp_excl`=0) leaves the tags unchanged and raises no alert.
- R8: A mark request for a new address when all entries are live replaces the line in entry 0. It raises a capacity alert (cause 1) for the displaced address.
- R9: `release_all` clears every tag in one cycle. It suppresses that cycle's snoop, eviction and mark, raises no alert, and does not change the mask or a pending alert.
- R10: When several events occur in the same cycle, every tag they hit is cleared. Only one event becomes the alert candidate, chosen in this order: exclusive-snoop hit, then eviction hit, then displacement. Within a cycle, the snoop and eviction act before the mark.
- R11: After reset, no tag is live and the block is unmasked. `alert_valid` is a single-cycle pulse per delivered alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mark_valid | input | 1 | Alert-marking load strobe |
| mark_addr | input | LINE_ADDR_W | Line address to watch |
| snp_valid | input | 1 | Snoop strobe |
| snp_excl | input | 1 | 1 = exclusive (invalidating) snoop, 0 = shared read snoop |
| snp_addr | input | LINE_ADDR_W | Snooped line address |
| evict_valid | input | 1 | Capacity eviction strobe |
| evict_addr | input | LINE_ADDR_W | Evicted line address |
| handler_exit | input | 1 | Software has left its alert handler |
| release_all | input | 1 | Drop every watch tag silently |
| alert_valid | output | 1 | Alert pulse |
| alert_cause | output | 1 | 0 = coherence loss, 1 = capacity loss |
| alert_addr | output | LINE_ADDR_W | Line address of the alert |

## Verification
Directed sequences first try each kind of loss on its own. An exclusive snoop and an eviction to a watched line show whether the cause bit is right. Snoops to unwatched lines and shared snoops show whether the block tells a tag hit apart from a miss, and a read from a write. Bursts of losses inside one handler window show whether the single pending slot keeps the first loss and drops the rest. A table filled to capacity and then marked again shows whether entry 0 is the one displaced. Same-cycle combinations and a release mixed with other events test the priority order. A long stretch of random traffic over a dozen addresses then drives all inputs together against a behavioural model.

// File: rtl/line_watch_pkg.sv
package line_watch_pkg;

   typedef enum logic {
      CAUSE_COHERENCE = 1'b0,
      CAUSE_CAPACITY  = 1'b1
   } watch_cause_e;

endpackage

// File: rtl/lw_first_free.sv
module lw_first_free #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] busy,
   output logic [WIDTH-1:0] pick,
   output logic             all_busy
);

   logic [WIDTH:0] seen_free;

   assign seen_free[0] = 1'b0;

   for (genvar i = 0; i < WIDTH; i++) begin : g_scan
      assign pick[i]        = ~busy[i] & ~seen_free[i];
      assign seen_free[i+1] = seen_free[i] | ~busy[i];
   end

   assign all_busy = ~seen_free[WIDTH];

endmodule

// File: rtl/lw_tag_store.sv
module lw_tag_store #(
   parameter int unsigned NUM_ENTRIES = 8,
   parameter int unsigned LINE_ADDR_W = 26
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   release_all,
   input  logic                   snp_inv,
   input  logic [LINE_ADDR_W-1:0] snp_addr,
   input  logic                   evict_valid,
   input  logic [LINE_ADDR_W-1:0] evict_addr,
   input  logic                   mark_valid,
   input  logic [LINE_ADDR_W-1:0] mark_addr,
   output logic [NUM_ENTRIES-1:0] tag_valid,
   output logic                   coh_hit,
   output logic                   cap_hit,
   output logic                   disp_hit,
   output logic [LINE_ADDR_W-1:0] disp_addr
);

   logic [NUM_ENTRIES-1:0] ent_v;
   logic [LINE_ADDR_W-1:0] ent_a [NUM_ENTRIES];
   logic [NUM_ENTRIES-1:0] snp_match;
   logic [NUM_ENTRIES-1:0] ev_match;
   logic [NUM_ENTRIES-1:0] mk_match;
   logic [NUM_ENTRIES-1:0] kept;
   logic [NUM_ENTRIES-1:0] free_pick;
   logic                   table_full;
   logic                   present;
   logic                   alloc;

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
      assign snp_match[i] = ent_v[i] & snp_inv     & (ent_a[i] == snp_addr);
      assign ev_match[i]  = ent_v[i] & evict_valid & (ent_a[i] == evict_addr);
      assign mk_match[i]  = (ent_a[i] == mark_addr);
   end

   // tags surviving this cycle's losses; the mark sees this view
   assign kept    = ent_v & ~(snp_match | ev_match);
   assign present = |(kept & mk_match);
   assign alloc   = mark_valid & ~present & ~release_all;

   lw_first_free #(.WIDTH(NUM_ENTRIES)) u_free (
      .busy     (kept),
      .pick     (free_pick),
      .all_busy (table_full)
   );

   assign coh_hit   = (|snp_match) & ~release_all;
   assign cap_hit   = (|ev_match) & ~release_all;
   assign disp_hit  = alloc & table_full;
   assign disp_addr = ent_a[0];
   assign tag_valid = ent_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_v <= '0;
         for (int i = 0; i < NUM_ENTRIES; i++) begin
            ent_a[i] <= '0;
         end
      end else if (release_all) begin
         ent_v <= '0;
      end else begin
         for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (alloc && !table_full && free_pick[i]) begin
               ent_v[i] <= 1'b1;
               ent_a[i] <= mark_addr;
            end else if (disp_hit && i == 0) begin
               ent_v[i] <= 1'b1;
               ent_a[i] <= mark_addr;
            end else begin
               ent_v[i] <= kept[i];
            end
         end
      end
   end

endmodule

// File: rtl/lw_alert_seq.sv
module lw_alert_seq
   import line_watch_pkg::*;
#(
   parameter int unsigned LINE_ADDR_W = 26
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ev_valid,
   input  watch_cause_e           ev_cause,
   input  logic [LINE_ADDR_W-1:0] ev_addr,
   input  logic                   handler_exit,
   output logic                   out_valid,
   output watch_cause_e           out_cause,
   output logic [LINE_ADDR_W-1:0] out_addr,
   output logic                   masked,
   output logic                   pending
);

   watch_cause_e           pend_cause;
   logic [LINE_ADDR_W-1:0] pend_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_cause  <= CAUSE_COHERENCE;
         out_addr   <= '0;
         masked     <= 1'b0;
         pending    <= 1'b0;
         pend_cause <= CAUSE_COHERENCE;
         pend_addr  <= '0;
      end else begin
         out_valid <= 1'b0;
         if (masked && handler_exit) begin
            if (pending) begin
               out_valid <= 1'b1;
               out_cause <= pend_cause;
               out_addr  <= pend_addr;
               pending   <= ev_valid;
               if (ev_valid) begin
                  pend_cause <= ev_cause;
                  pend_addr  <= ev_addr;
               end
            end else if (ev_valid) begin
               out_valid <= 1'b1;
               out_cause <= ev_cause;
               out_addr  <= ev_addr;
            end else begin
               masked <= 1'b0;
            end
         end else if (masked) begin
            if (ev_valid && !pending) begin
               pending    <= 1'b1;
               pend_cause <= ev_cause;
               pend_addr  <= ev_addr;
            end
         end else if (ev_valid) begin
            out_valid <= 1'b1;
            out_cause <= ev_cause;
            out_addr  <= ev_addr;
            masked    <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/line_watch_monitor.sv
module line_watch_monitor
   import line_watch_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 8,
   parameter int unsigned LINE_ADDR_W = 26
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   mark_valid,
   input  logic [LINE_ADDR_W-1:0] mark_addr,
   input  logic                   snp_valid,
   input  logic                   snp_excl,
   input  logic [LINE_ADDR_W-1:0] snp_addr,
   input  logic                   evict_valid,
   input  logic [LINE_ADDR_W-1:0] evict_addr,
   input  logic                   handler_exit,
   input  logic                   release_all,
   output logic                   alert_valid,
   output logic                   alert_cause,
   output logic [LINE_ADDR_W-1:0] alert_addr
);

   if (NUM_ENTRIES < 2 || NUM_ENTRIES > 64) begin : g_bad_entries
      $error("line_watch_monitor: NUM_ENTRIES must lie in 2..64");
   end
   if (LINE_ADDR_W < 1 || LINE_ADDR_W > 64) begin : g_bad_addr
      $error("line_watch_monitor: LINE_ADDR_W must lie in 1..64");
   end

   logic [NUM_ENTRIES-1:0] tag_valid;
   logic                   coh_hit;
   logic                   cap_hit;
   logic                   disp_hit;
   logic [LINE_ADDR_W-1:0] disp_addr;
   logic                   ev_valid;
   watch_cause_e           ev_cause;
   logic [LINE_ADDR_W-1:0] ev_addr;
   watch_cause_e           out_cause;
   logic                   masked;
   logic                   pending;

   lw_tag_store #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .LINE_ADDR_W (LINE_ADDR_W)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .release_all (release_all),
      .snp_inv     (snp_valid & snp_excl),
      .snp_addr    (snp_addr),
      .evict_valid (evict_valid),
      .evict_addr  (evict_addr),
      .mark_valid  (mark_valid),
      .mark_addr   (mark_addr),
      .tag_valid   (tag_valid),
      .coh_hit     (coh_hit),
      .cap_hit     (cap_hit),
      .disp_hit    (disp_hit),
      .disp_addr   (disp_addr)
   );

   // one candidate per cycle: coherence loss, then eviction, then displacement
   always_comb begin
      ev_valid = coh_hit | cap_hit | disp_hit;
      if (coh_hit) begin
         ev_cause = CAUSE_COHERENCE;
         ev_addr  = snp_addr;
      end else if (cap_hit) begin
         ev_cause = CAUSE_CAPACITY;
         ev_addr  = evict_addr;
      end else begin
         ev_cause = CAUSE_CAPACITY;
         ev_addr  = disp_addr;
      end
   end

   lw_alert_seq #(
      .LINE_ADDR_W (LINE_ADDR_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .ev_valid     (ev_valid),
      .ev_cause     (ev_cause),
      .ev_addr      (ev_addr),
      .handler_exit (handler_exit),
      .out_valid    (alert_valid),
      .out_cause    (out_cause),
      .out_addr     (alert_addr),
      .masked       (masked),
      .pending      (pending)
   );

   assign alert_cause = out_cause;

endmodule

// File: rtl/lw_monitor_checker.sv
module lw_monitor_checker #(
   parameter int unsigned NUM_ENTRIES = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   mark_valid,
   input logic                   snp_valid,
   input logic                   snp_excl,
   input logic                   evict_valid,
   input logic                   handler_exit,
   input logic                   release_all,
   input logic                   alert_valid,
   input logic                   alert_cause,
   input logic [NUM_ENTRIES-1:0] tag_valid,
   input logic                   coh_hit,
   input logic                   cap_hit,
   input logic                   masked,
   input logic                   pending
);

   // R2: unmasked coherence loss gives a coherence alert next cycle
   a_r2_coh_alert: assert property (@(posedge clk) disable iff (!rst_n)
      (coh_hit && !masked) |=> (alert_valid && alert_cause == 1'b0));

   // R3: unmasked eviction loss without a snoop hit gives a capacity alert
   a_r3_cap_alert: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_hit && !coh_hit && !masked) |=> (alert_valid && alert_cause == 1'b1));

   // R4: a second alert needs a handler exit in between
   a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      alert_valid |=> (!alert_valid || $past(handler_exit)));

   // R5: a pending alert only exists under the mask
   a_r5_pend_masked: assert property (@(posedge clk) disable iff (!rst_n)
      pending |-> masked);

   // R6: no loss input while unmasked means no alert
   a_r6_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (!masked && !(snp_valid && snp_excl) && !evict_valid && !mark_valid) |=> !alert_valid);

   // R9: release empties the table
   a_r9_release_clear: assert property (@(posedge clk) disable iff (!rst_n)
      release_all |=> (tag_valid == '0));

   // R9: release raises nothing
   a_r9_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (release_all && !masked) |=> !alert_valid);

endmodule

bind line_watch_monitor lw_monitor_checker #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mark_valid   (mark_valid),
   .snp_valid    (snp_valid),
   .snp_excl     (snp_excl),
   .evict_valid  (evict_valid),
   .handler_exit (handler_exit),
   .release_all  (release_all),
   .alert_valid  (alert_valid),
   .alert_cause  (alert_cause),
   .tag_valid    (tag_valid),
   .coh_hit      (coh_hit),
   .cap_hit      (cap_hit),
   .masked       (masked),
   .pending      (pending)
);

// File: tb/line_watch_monitor_bench.sv
`timescale 1ns/1ps
module line_watch_monitor_bench;

   localparam int N  = 8;
   localparam int AW = 26;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mark_valid = 1'b0;
   logic [AW-1:0] mark_addr = '0;
   logic          snp_valid = 1'b0;
   logic          snp_excl = 1'b0;
   logic [AW-1:0] snp_addr = '0;
   logic          evict_valid = 1'b0;
   logic [AW-1:0] evict_addr = '0;
   logic          handler_exit = 1'b0;
   logic          release_all = 1'b0;
   logic          alert_valid;
   logic          alert_cause;
   logic [AW-1:0] alert_addr;

   int    total = 0;
   int    bad = 0;
   bit    finished = 1'b0;
   string cur_req = "R11";

   always #4 clk = ~clk;

   line_watch_monitor #(.NUM_ENTRIES(N), .LINE_ADDR_W(AW)) u_line_watch_monitor (
      .clk (clk), .rst_n (rst_n),
      .mark_valid (mark_valid), .mark_addr (mark_addr),
      .snp_valid (snp_valid), .snp_excl (snp_excl), .snp_addr (snp_addr),
      .evict_valid (evict_valid), .evict_addr (evict_addr),
      .handler_exit (handler_exit), .release_all (release_all),
      .alert_valid (alert_valid), .alert_cause (alert_cause), .alert_addr (alert_addr)
   );

   // ---------------- behavioural reference model ----------------
   bit            m_v [N];
   logic [AW-1:0] m_a [N];
   bit            m_mask, m_pend;
   bit            p_cause;
   logic [AW-1:0] p_addr;
   bit            e_v, e_cause;
   logic [AW-1:0] e_addr;
   bit            ev, ev_cause, coh, cap, disp, found, placed;
   logic [AW-1:0] ev_addr, d_addr;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin m_v[i] = 0; m_a[i] = '0; end
         m_mask = 0; m_pend = 0; e_v = 0; e_cause = 0; e_addr = '0;
      end else begin
         ev = 0; ev_cause = 0; ev_addr = '0;
         if (release_all) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
         end else begin
            coh = 0; cap = 0; disp = 0;
            for (int i = 0; i < N; i++) begin
               if (m_v[i] && snp_valid && snp_excl && m_a[i] == snp_addr) begin coh = 1; m_v[i] = 0; end
               if (m_v[i] && evict_valid && m_a[i] == evict_addr) begin cap = 1; m_v[i] = 0; end
            end
            if (mark_valid) begin
               found = 0;
               for (int i = 0; i < N; i++) if (m_v[i] && m_a[i] == mark_addr) found = 1;
               if (!found) begin
                  placed = 0;
                  for (int i = 0; i < N; i++)
                     if (!placed && !m_v[i]) begin m_v[i] = 1; m_a[i] = mark_addr; placed = 1; end
                  if (!placed) begin disp = 1; d_addr = m_a[0]; m_a[0] = mark_addr; end
               end
            end
            if (coh) begin ev = 1; ev_cause = 0; ev_addr = snp_addr; end
            else if (cap) begin ev = 1; ev_cause = 1; ev_addr = evict_addr; end
            else if (disp) begin ev = 1; ev_cause = 1; ev_addr = d_addr; end
         end
         e_v = 0;
         if (m_mask && handler_exit) begin
            if (m_pend) begin
               e_v = 1; e_cause = p_cause; e_addr = p_addr; m_pend = ev;
               if (ev) begin p_cause = ev_cause; p_addr = ev_addr; end
            end else if (ev) begin
               e_v = 1; e_cause = ev_cause; e_addr = ev_addr;
            end else m_mask = 0;
         end else if (m_mask) begin
            if (ev && !m_pend) begin m_pend = 1; p_cause = ev_cause; p_addr = ev_addr; end
         end else if (ev) begin
            e_v = 1; e_cause = ev_cause; e_addr = ev_addr; m_mask = 1;
         end
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         total++;
         if (alert_valid !== e_v ||
             (e_v && (alert_cause !== e_cause || alert_addr !== e_addr))) begin
            bad++;
            $display("FAIL %s model compare: got v=%0b c=%0b a=%h exp v=%0b c=%0b a=%h",
                     cur_req, alert_valid, alert_cause, alert_addr, e_v, e_cause, e_addr);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(negedge clk);
      mark_valid = 0; snp_valid = 0; snp_excl = 0; evict_valid = 0;
      handler_exit = 0; release_all = 0;
   endtask

   task automatic do_mark(input logic [AW-1:0] a);
      tick(); mark_valid = 1; mark_addr = a;
   endtask

   task automatic do_snp(input logic [AW-1:0] a, input bit x);
      tick(); snp_valid = 1; snp_excl = x; snp_addr = a;
   endtask

   task automatic do_evict(input logic [AW-1:0] a);
      tick(); evict_valid = 1; evict_addr = a;
   endtask

   task automatic do_exit();
      tick(); handler_exit = 1;
   endtask

   task automatic expect_alert(input string req, input bit c, input logic [AW-1:0] a);
      total++;
      if (alert_valid !== 1'b1 || alert_cause !== c || alert_addr !== a) begin
         bad++;
         $display("FAIL %s alert: got v=%0b c=%0b a=%h exp v=1 c=%0b a=%h",
                  req, alert_valid, alert_cause, alert_addr, c, a);
      end
   endtask

   task automatic expect_none(input string req);
      total++;
      if (alert_valid !== 1'b0) begin
         bad++;
         $display("FAIL %s quiet: got v=%0b exp v=0", req, alert_valid);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: got timeout exp finish");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_none("R11");                   // reset state
      rst_n = 1;
      tick();

      cur_req = "R2";                       // R1 mark then R2 coherence loss
      do_mark(26'h100); do_mark(26'h101);
      do_snp(26'h100, 1); tick();
      expect_alert("R2", 0, 26'h100);
      tick(); expect_none("R11");           // one-cycle pulse
      do_exit(); tick();

      cur_req = "R7";
      do_snp(26'h101, 0); tick(); tick();
      expect_none("R7");
      do_snp(26'h101, 1); tick();
      expect_alert("R7", 0, 26'h101);       // tag survived the shared snoop
      do_exit(); tick();

      cur_req = "R3";
      do_mark(26'h200); do_evict(26'h200); tick();
      expect_alert("R3", 1, 26'h200);
      do_exit(); tick();

      cur_req = "R6";
      do_mark(26'h300);
      do_snp(26'h3AA, 1); tick(); expect_none("R6");
      do_evict(26'h3BB); tick(); expect_none("R6");
      do_snp(26'h300, 1); tick();
      expect_alert("R6", 0, 26'h300);        // untouched tag still live
      do_exit(); tick();

      cur_req = "R4";
      do_mark(26'h400); do_mark(26'h401); do_mark(26'h402);
      do_snp(26'h400, 1); tick();
      expect_alert("R4", 0, 26'h400);
      do_snp(26'h401, 1); tick(); expect_none("R4");
      do_evict(26'h402); tick(); expect_none("R4");
      cur_req = "R5";
      do_exit(); tick();
      expect_alert("R5", 0, 26'h401);
      do_exit(); tick();
      do_snp(26'h402, 1); tick(); tick();
      expect_none("R5");                     // dropped event still cleared its tag

      cur_req = "R8";
      tick(); release_all = 1;
      for (int i = 0; i < N; i++) do_mark(26'h500 + 26'(i));
      do_mark(26'h5FF); tick();
      expect_alert("R8", 1, 26'h500);
      do_exit(); tick();
      do_snp(26'h5FF, 1); tick();
      expect_alert("R8", 0, 26'h5FF);
      do_exit(); tick();
      do_snp(26'h500, 1); tick(); tick(); expect_none("R8");

      cur_req = "R9";
      tick(); release_all = 1;
      do_mark(26'h600);
      tick(); release_all = 1; snp_valid = 1; snp_excl = 1; snp_addr = 26'h600;
      mark_valid = 1; mark_addr = 26'h601;
      tick(); expect_none("R9");
      do_snp(26'h601, 1); tick(); tick(); expect_none("R9");
      do_mark(26'h602); tick(); release_all = 1;
      do_snp(26'h602, 1); tick(); tick(); expect_none("R9");

      cur_req = "R10";
      do_mark(26'h700); do_mark(26'h701);
      tick(); snp_valid = 1; snp_excl = 1; snp_addr = 26'h700;
      evict_valid = 1; evict_addr = 26'h701;
      tick(); expect_alert("R10", 0, 26'h700);
      do_exit(); tick();
      do_evict(26'h701); tick(); tick(); expect_none("R10");

      cur_req = "R1";
      do_mark(26'h800); do_mark(26'h800);
      do_snp(26'h800, 1); tick(); expect_alert("R1", 0, 26'h800);
      do_exit(); tick();
      do_snp(26'h800, 1); tick(); tick(); expect_none("R1");  // no duplicate entry

      cur_req = "R10 random";
      for (int k = 0; k < 3000; k++) begin
         tick();
         if ($urandom_range(0, 99) < 40) begin mark_valid = 1; mark_addr = 26'h900 + 26'($urandom_range(0, 11)); end
         if ($urandom_range(0, 99) < 30) begin snp_valid = 1; snp_excl = 1'($urandom_range(0, 1)); snp_addr = 26'h900 + 26'($urandom_range(0, 11)); end
         if ($urandom_range(0, 99) < 20) begin evict_valid = 1; evict_addr = 26'h900 + 26'($urandom_range(0, 11)); end
         if ($urandom_range(0, 99) < 15) handler_exit = 1;
         if ($urandom_range(0, 99) < 2)  release_all = 1;
      end
      tick(); tick();
      finish_run();
   end

endmodule